// File: doc/BRIEF.md
# Strobe watchdog with open-pin detection

This block supervises a processor through one strobe input. Software must toggle the strobe regularly. A change of level in either direction restarts a timeout counter. If the counter runs a full window of `TIMEOUT_CYCLES` clock cycles without seeing a change, the block emits a one-cycle request to the reset generator. While the reset generator reports that its reset output is active, the counter is held at zero. Counting starts again once that output is released.

The block also steers a weak pull on the strobe pin, so that it can tell an unconnected or tri-stated pin from a driven one. The pull points low for the first seven eighths of every window and high for the last eighth. A pin that only ever follows this imposed pattern is treated as floating, and the watchdog stays silent. As soon as the sampled level disagrees with the pull direction, the pin counts as driven and normal supervision applies.

The raw level passes through a two-stage synchroniser. For `SETTLE_CYCLES` cycles after each change of pull direction, the block ignores edges and disagreements, so that the pin's own response to the pull is never taken as a strobe.

Top module: `strobe_watchdog`

## Requirements
- R1: The raw strobe passes through two synchronising flops. A level change that is not inside a blanking window restarts the count. Such an edge, first sampled at clock edge P+1, moves the next timeout pulse to clock edge P+3+TIMEOUT_CYCLES. Rising and falling changes act alike.
- R2: If the count runs without a restart, `timeoutPulse` is high for exactly one cycle at the end of each window. The pulses repeat every TIMEOUT_CYCLES cycles.
- R3: While `resetActive` is 1, the count stays at zero, no pulse is produced and `pullHigh` is 0. If `resetActive` falls just after clock edge P, the next pulse comes at edge P+TIMEOUT_CYCLES.
- R4: `pullHigh` is 1 for the last TIMEOUT_CYCLES/8 cycles of each window and 0 otherwise. TIMEOUT_CYCLES must be a multiple of 8. A timeout pulse always ends a high phase, so it coincides with `pullHigh` returning to 0.
- R5: A pin whose synchronised level matches `pullHigh` for a whole window, outside the blanking windows, is treated as floating. No pulse is issued for that window.
- R6: For SETTLE_CYCLES cycles after each change of `pullHigh`, synchronised edges do not restart the count, and level disagreements are not taken as evidence of a driven pin.
- R7: A synchronised level that differs from `pullHigh` outside a blanking window marks the pin as driven. The window in progress then ends with a timeout pulse, unless a restart comes first.
- R8: While `rstN` is low, `timeoutPulse` and `pullHigh` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| strobeRaw | input | 1 | Unsynchronised level of the strobe pin |
| resetActive | input | 1 | 1 while the reset generator holds its output active |
| timeoutPulse | output | 1 | One-cycle reset request at the end of a window |
| pullHigh | output | 1 | Pull direction for the strobe pin: 1 = pull up, 0 = pull down |

## Verification
The assertions check every cycle that the timeout pulse is single-cycle and never follows a cycle of `resetActive`. They also check that each pulse closes a high pull phase, and that the pull is low while the reset generator holds the block. Only the bench scenarios can show the exact cycle of each pulse after a strobe edge or a reset release, and the suppression of pulses for a pin that follows the pull. The same applies to the eight-cycle high phase that survives the pin's own echo, and to the return to supervision once the pin disagrees with the pull.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic hold;     // reset generator active: keep count at zero
    logic restart;  // accepted strobe edge: count from zero
  } wdt_ctl_t;

  // datapath -> control status
  typedef struct packed {
    logic edgeSeen;  // synchronised level changed this cycle
    logic mismatch;  // synchronised level differs from pull direction
    logic blanking;  // inside settle window after a pull change
    logic atLast;    // count is at the final cycle of the window
  } wdt_stat_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 112_000_000,
  parameter int SETTLE_CYCLES  = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      strobeRaw,
  input  wdt_ctl_t  ctl,
  output wdt_stat_t stat,
  output logic      pullHigh
);
  localparam int CNT_W   = $clog2(TIMEOUT_CYCLES);
  localparam int BLANK_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_C       = CNT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [CNT_W-1:0] HIGH_START_C = CNT_W'(TIMEOUT_CYCLES - TIMEOUT_CYCLES / 8);
  localparam logic [BLANK_W-1:0] SETTLE_C   = BLANK_W'(SETTLE_CYCLES);

  logic [1:0]         syncQ;
  logic               prevLevel;
  logic [CNT_W-1:0]   count, countNext;
  logic [BLANK_W-1:0] blankCnt;
  logic               pullNext;

  // two-stage synchroniser plus edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '0;
      prevLevel <= 1'b0;
    end else begin
      syncQ     <= {syncQ[0], strobeRaw};
      prevLevel <= syncQ[1];
    end
  end

  always_comb begin
    if (ctl.hold || ctl.restart) countNext = '0;
    else if (count == LAST_C)    countNext = '0;
    else                         countNext = count + 1'b1;
    pullNext = (countNext >= HIGH_START_C);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      pullHigh <= 1'b0;
      blankCnt <= '0;
    end else begin
      count    <= countNext;
      pullHigh <= pullNext;
      if (pullNext != pullHigh)  blankCnt <= SETTLE_C;
      else if (blankCnt != '0)   blankCnt <= blankCnt - 1'b1;
    end
  end

  assign stat.edgeSeen = syncQ[1] ^ prevLevel;
  assign stat.mismatch = syncQ[1] ^ pullHigh;
  assign stat.blanking = (blankCnt != '0);
  assign stat.atLast   = (count == LAST_C);
endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      resetActive,
  input  wdt_stat_t stat,
  output wdt_ctl_t  ctl,
  output logic      timeoutPulse
);
  logic drivenSeen;
  logic validEdge, evidence, wrap, fire, clearEvidence;

  always_comb begin
    validEdge     = stat.edgeSeen && !stat.blanking;
    ctl.hold      = resetActive;
    ctl.restart   = validEdge && !resetActive;
    evidence      = drivenSeen || (stat.mismatch && !stat.blanking);
    wrap          = stat.atLast && !ctl.hold && !ctl.restart;
    fire          = wrap && evidence;
    clearEvidence = ctl.hold || ctl.restart || wrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drivenSeen   <= 1'b0;
      timeoutPulse <= 1'b0;
    end else begin
      drivenSeen   <= clearEvidence ? 1'b0 : evidence;
      timeoutPulse <= fire;
    end
  end
endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 112_000_000,
  parameter int SETTLE_CYCLES  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic strobeRaw,
  input  logic resetActive,
  output logic timeoutPulse,
  output logic pullHigh
);
  wdt_ctl_t  ctl;
  wdt_stat_t stat;

  wdt_datapath #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobeRaw(strobeRaw),
    .ctl      (ctl),
    .stat     (stat),
    .pullHigh (pullHigh)
  );

  wdt_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .resetActive (resetActive),
    .stat        (stat),
    .ctl         (ctl),
    .timeoutPulse(timeoutPulse)
  );
endmodule

// File: rtl/strobe_watchdog_checker.sv
module strobe_watchdog_checker (
  input logic clk,
  input logic rstN,
  input logic resetActive,
  input logic timeoutPulse,
  input logic pullHigh
);
  // R2: request lasts one cycle
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

  // R3: no request after a cycle with the reset generator active
  p_no_fire_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    resetActive |=> !timeoutPulse);

  // R3: pull is low while held
  p_pull_low_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    resetActive |=> !pullHigh);

  // R4: a request closes a high pull phase
  p_fire_after_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> $past(pullHigh));

  // R4: a request coincides with the pull returning low
  p_fire_pull_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> !pullHigh);
endmodule

bind strobe_watchdog strobe_watchdog_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .resetActive (resetActive),
  .timeoutPulse(timeoutPulse),
  .pullHigh    (pullHigh)
);

// File: tb/strobe_watchdog_tb.sv
`timescale 1ns/1ps
module strobe_watchdog_tb;
  localparam int T  = 64;
  localparam int ST = 4;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic resetActive = 1'b1;
  logic drive = 1'b1;
  logic driveVal = 1'b0;
  logic timeoutPulse, pullHigh;
  wire  strobePin = drive ? driveVal : pullHigh;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int expQ[$];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  strobe_watchdog #(.TIMEOUT_CYCLES(T), .SETTLE_CYCLES(ST)) u_dut (
    .clk(clk), .rstN(rstN), .strobeRaw(strobePin), .resetActive(resetActive),
    .timeoutPulse(timeoutPulse), .pullHigh(pullHigh)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // monitor: pop expected pulse cycle on each observed pulse
  always @(negedge clk) begin
    if (rstN && timeoutPulse) begin
      if (expQ.size() == 0) check(1'b0, "R2/R5 unexpected pulse", cyc, -1);
      else begin
        int e;
        e = expQ.pop_front();
        check(cyc == e, "R1/R2/R3/R7 pulse cycle", cyc, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    finishRun();
  end

  initial begin
    int p, s, r, highCnt;
    #1 rstN = 1'b0;
    tick(5);
    check(timeoutPulse == 1'b0, "R8 pulse in reset", timeoutPulse, 0);
    check(pullHigh == 1'b0, "R8 pull in reset", pullHigh, 0);
    rstN = 1'b1;
    tick(10);                                   // R3 held: no pulse allowed
    check(pullHigh == 1'b0, "R3 pull while held", pullHigh, 0);

    // R3 release then R2 periodic pulses with pin held low
    resetActive = 1'b0; p = cyc;
    expQ.push_back(p + T);
    expQ.push_back(p + 2 * T);
    tick(2 * T + 2);
    check(expQ.size() == 0, "R2 periodic pulses seen", expQ.size(), 0);

    // R3 hold again mid-window: count cleared, restart from release
    resetActive = 1'b1;
    tick(20);
    resetActive = 1'b0; p = cyc;
    expQ.push_back(p + T);
    tick(T + 2);
    check(expQ.size() == 0, "R3 pulse after release", expQ.size(), 0);

    // R1 strobes in both directions keep it quiet
    tick(30);
    for (int k = 0; k < 6; k++) begin
      driveVal = ~driveVal;                     // rising then falling alternately
      s = cyc;
      tick(40);
    end
    check(driveVal == 1'b0, "R1 strobe sequence ended low", driveVal, 0);
    expQ.push_back(s + 3 + T);                  // R1 last edge sets the timeout
    tick(T + 3 + 3 - 40);
    check(expQ.size() == 0, "R1 pulse after last strobe", expQ.size(), 0);

    // R5 R6 float: release the pin in the low phase
    drive = 1'b0;
    tick(T);
    highCnt = 0;
    for (int k = 0; k < T; k++) begin
      if (pullHigh) highCnt++;
      tick(1);
    end
    check(highCnt == T / 8, "R4 R6 high phase length", highCnt, T / 8);
    tick(T);
    check(expQ.size() == 0, "R5 no pulse while floating", expQ.size(), 0);

    // R7 drive low against a high pull
    while (pullHigh) tick(1);
    while (!pullHigh) tick(1);
    r = cyc;
    drive = 1'b1; driveVal = 1'b0;
    expQ.push_back(r + T / 8);
    expQ.push_back(r + T / 8 + T);
    tick(T / 8 + T + 4);
    check(expQ.size() == 0, "R7 pulses after pin driven", expQ.size(), 0);
    finishRun();
  end
endmodule